// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps an 8-bit record of which event brought the system out of its last reset. Five reset sources arrive as single-cycle strobes: an external reset pin, a watchdog timeout, an illegal opcode, an illegal-address access and a low-voltage detect. An illegal-address strobe counts only when a companion qualifier marks the access as an opcode fetch. The power-on reset is a separate active-high input. It forces the record to a known value that shows only the power-on cause.

Software reads the byte through a simple bus port. A read whose address matches the register's fixed address returns the flags on the next cycle. The same read clears every flag. A cause that is set in the same cycle as that read survives the clear. Flags from several resets pile up until software reads the register. Writes and reads at other addresses leave the record as it is.

Top module: `reset_cause_reg`

## Requirements
- R1: While `por_i` is high, `rd_data_o` is 0 and the flag byte is forced to 0x80 (bit 7 set, every other bit clear). A power-on reset in the same cycle as any other source still yields 0x80.
- R2: An external-pin strobe (`pin_rst_i`) sets bit 6.
- R3: A watchdog strobe (`wdog_rst_i`) sets bit 5.
- R4: An illegal-opcode strobe (`badop_rst_i`) sets bit 4.
- R5: An illegal-address strobe (`badaddr_rst_i`) sets bit 3 only when `fetch_i` is high in the same cycle. Otherwise it changes nothing.
- R6: A low-voltage strobe (`lowv_rst_i`) sets bit 1.
- R7: Bits 2 and 0 always read 0.
- R8: A matched read is `bus_en_i`=1, `bus_we_i`=0 and `bus_addr_i`=`REG_ADDR`. It places the flag byte as it stood before the read on `rd_data_o` one cycle later. At that same clock edge every flag clears.
- R9: In any cycle after a clock edge that saw no matched read, `rd_data_o` is 0.
- R10: Flags set by different sources accumulate until a matched read clears them.
- R11: A source strobe in the same cycle as a matched read has its flag set after that edge. The read itself returns the older value.
- R12: A read at any other address leaves the flags unchanged.
- R13: A write (`bus_en_i`=1, `bus_we_i`=1) at any address, including `REG_ADDR`, leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| pin_rst_i | input | 1 | External pin reset strobe |
| wdog_rst_i | input | 1 | Watchdog timeout strobe |
| badop_rst_i | input | 1 | Illegal opcode strobe |
| badaddr_rst_i | input | 1 | Illegal address access strobe |
| fetch_i | input | 1 | Qualifies the illegal-address strobe as an opcode fetch |
| lowv_rst_i | input | 1 | Low-voltage detect strobe |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus access is a write |
| bus_addr_i | input | ADDR_W | Bus address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench builds the block with an 8-bit address and `REG_ADDR` = 0x5C. With an address space this narrow, random traffic generates matched reads, near-miss reads and writes to the register's own address at useful rates. Random source strobes and occasional power-on pulses are interleaved with reads. This covers accumulation, collisions between a set and a clear, and power-on winning over simultaneous sources. A bench model predicts every read.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int FLAG_W  = 8;
  localparam int N_SRC   = 5;
  localparam int POR_BIT = 7;
  // source index: 0 pin, 1 watchdog, 2 illegal opcode, 3 illegal address, 4 low voltage
  localparam int SRC_BIT [N_SRC] = '{6, 5, 4, 3, 1};
  localparam logic [FLAG_W-1:0] POR_VALUE = 8'h80;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/rcs_src_qual.sv
module rcs_src_qual
  import rcs_pkg::*;
(
  input  logic             pin_i,
  input  logic             wdog_i,
  input  logic             badop_i,
  input  logic             badaddr_i,
  input  logic             fetch_i,
  input  logic             lowv_i,
  output logic [N_SRC-1:0] set_o
);
  always_comb begin
    set_o[0] = pin_i;
    set_o[1] = wdog_i;
    set_o[2] = badop_i;
    set_o[3] = badaddr_i & fetch_i;  // only opcode fetches count
    set_o[4] = lowv_i;
  end
endmodule

// File: rtl/rcs_flag_store.sv
module rcs_flag_store
  import rcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] set_i,
  output flags_t           flags_o
);
  logic             por_q;
  logic [N_SRC-1:0] src_q;

  always_ff @(posedge clk_i) begin
    if (por_i)      por_q <= 1'b1;
    else if (clr_i) por_q <= 1'b0;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i) begin
      if (por_i)         src_q[i] <= 1'b0;
      else if (set_i[i]) src_q[i] <= 1'b1;  // set beats clear
      else if (clr_i)    src_q[i] <= 1'b0;
    end
  end

  always_comb begin
    flags_o          = '0;
    flags_o[POR_BIT] = por_q;
    for (int i = 0; i < N_SRC; i++) flags_o[SRC_BIT[i]] = src_q[i];
  end
endmodule

// File: rtl/rcs_bus_port.sv
module rcs_bus_port
  import rcs_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0F40
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  flags_t            flags_i,
  output logic              hit_o,
  output flags_t            rd_data_o
);
  assign hit_o = bus_en_i && !bus_we_i && (bus_addr_i == REG_ADDR);

  always_ff @(posedge clk_i) begin
    if (por_i)      rd_data_o <= '0;
    else if (hit_o) rd_data_o <= flags_i;
    else            rd_data_o <= '0;
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcs_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0F40
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              pin_rst_i,
  input  logic              wdog_rst_i,
  input  logic              badop_rst_i,
  input  logic              badaddr_rst_i,
  input  logic              fetch_i,
  input  logic              lowv_rst_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [N_SRC-1:0] set_w;
  logic             hit_w;
  flags_t           flags_w;

  rcs_src_qual u_qual (
    .pin_i     (pin_rst_i),
    .wdog_i    (wdog_rst_i),
    .badop_i   (badop_rst_i),
    .badaddr_i (badaddr_rst_i),
    .fetch_i   (fetch_i),
    .lowv_i    (lowv_rst_i),
    .set_o     (set_w)
  );

  rcs_flag_store u_store (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .clr_i   (hit_w),
    .set_i   (set_w),
    .flags_o (flags_w)
  );

  rcs_bus_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_port (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .bus_en_i   (bus_en_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .flags_i    (flags_w),
    .hit_o      (hit_w),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0F40
) (
  input logic              clk_i,
  input logic              por_i,
  input logic              pin_rst_i,
  input logic              wdog_rst_i,
  input logic              badop_rst_i,
  input logic              badaddr_rst_i,
  input logic              fetch_i,
  input logic              lowv_rst_i,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        flags_i,
  input logic [7:0]        rd_data_o
);
  logic rd_hit, any_src;
  assign rd_hit  = bus_en_i && !bus_we_i && (bus_addr_i == REG_ADDR);
  assign any_src = pin_rst_i | wdog_rst_i | badop_rst_i | (badaddr_rst_i & fetch_i) | lowv_rst_i;

  assert_por_value_R1: assert property (@(posedge clk_i)
    por_i |=> (flags_i == 8'h80 && rd_data_o == 8'h00));
  assert_pin_sets_R2: assert property (@(posedge clk_i) disable iff (por_i)
    pin_rst_i |=> flags_i[6]);
  assert_wdog_sets_R3: assert property (@(posedge clk_i) disable iff (por_i)
    wdog_rst_i |=> flags_i[5]);
  assert_badop_sets_R4: assert property (@(posedge clk_i) disable iff (por_i)
    badop_rst_i |=> flags_i[4]);
  assert_fetch_sets_R5: assert property (@(posedge clk_i) disable iff (por_i)
    (badaddr_rst_i && fetch_i) |=> flags_i[3]);
  assert_data_access_ignored_R5: assert property (@(posedge clk_i) disable iff (por_i)
    (badaddr_rst_i && !fetch_i && !flags_i[3]) |=> !flags_i[3]);
  assert_lowv_sets_R6: assert property (@(posedge clk_i) disable iff (por_i)
    lowv_rst_i |=> flags_i[1]);
  assert_unimpl_zero_R7: assert property (@(posedge clk_i) disable iff (por_i)
    rd_hit |=> (rd_data_o[2] == 1'b0 && rd_data_o[0] == 1'b0));
  assert_read_returns_R8: assert property (@(posedge clk_i) disable iff (por_i)
    rd_hit |=> rd_data_o == $past(flags_i));
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (por_i)
    (rd_hit && !any_src) |=> flags_i == 8'h00);
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (por_i)
    !rd_hit |=> rd_data_o == 8'h00);
  assert_no_hit_hold_R12: assert property (@(posedge clk_i) disable iff (por_i)
    (!rd_hit && !any_src) |=> $stable(flags_i));
endmodule

bind reset_cause_reg rcs_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rcs_checker (
  .clk_i         (clk_i),
  .por_i         (por_i),
  .pin_rst_i     (pin_rst_i),
  .wdog_rst_i    (wdog_rst_i),
  .badop_rst_i   (badop_rst_i),
  .badaddr_rst_i (badaddr_rst_i),
  .fetch_i       (fetch_i),
  .lowv_rst_i    (lowv_rst_i),
  .bus_en_i      (bus_en_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .flags_i       (flags_w),
  .rd_data_o     (rd_data_o)
);

// File: tb/test_reset_cause_reg.sv
module test_reset_cause_reg;
  localparam int         AW  = 8;
  localparam logic [7:0] REG = 8'h5C;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic por = 1'b1, pin = 1'b0, wd = 1'b0, op = 1'b0, ad = 1'b0, fe = 1'b0, lv = 1'b0;
  logic en = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  logic [7:0] model = 8'h80;
  bit done = 0;

  reset_cause_reg #(.ADDR_W(AW), .REG_ADDR(REG)) i_reset_cause_reg (
    .clk_i(clk), .por_i(por), .pin_rst_i(pin), .wdog_rst_i(wd), .badop_rst_i(op),
    .badaddr_rst_i(ad), .fetch_i(fe), .lowv_rst_i(lv), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .rd_data_o(rd_data));

  // s = {pin, wd, op, ad, lv}
  function automatic logic [7:0] set_byte(input logic [4:0] s, input logic f);
    return {1'b0, s[4], s[3], s[2], s[1] & f, 1'b0, s[0], 1'b0};
  endfunction

  function automatic logic [7:0] next_model(input logic [7:0] m, input logic p,
      input logic [4:0] s, input logic f, input logic hit);
    if (p) return 8'h80;
    return (hit ? 8'h00 : m) | set_byte(s, f);
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: rd_data actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check after the following posedge
  task automatic tick(input logic p, input logic [4:0] s, input logic f, input logic e,
      input logic w, input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic hit;
    @(negedge clk);
    por = p; {pin, wd, op, ad, lv} = s; fe = f; en = e; we = w; addr = a;
    hit = e && !w && (a == REG);
    @(posedge clk);
    #1;
    model = next_model(model, p, s, f, hit);
    check(rd_data, exp, tag);
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    tick(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, REG, exp, tag);
  endtask

  task automatic pulse(input logic [4:0] s, input logic f, input string tag);
    tick(1'b0, s, f, 1'b0, 1'b0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(1'b1, 5'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R1 reset output");
    tick(1'b1, 5'b10000, 1'b0, 1'b1, 1'b0, REG, 8'h00, "R1 read during reset");
    rd(8'h80, "R1 power-on value");
    rd(8'h00, "R8 cleared by read");
    pulse(5'b10000, 1'b0, "R9 idle after pin"); rd(8'h40, "R2 pin flag");
    pulse(5'b01000, 1'b0, "R9 idle");          rd(8'h20, "R3 watchdog flag");
    pulse(5'b00100, 1'b0, "R9 idle");          rd(8'h10, "R4 illegal opcode flag");
    pulse(5'b00010, 1'b0, "R9 idle");          rd(8'h00, "R5 data access ignored");
    pulse(5'b00010, 1'b1, "R9 idle");          rd(8'h08, "R5 fetch flag");
    pulse(5'b00001, 1'b0, "R9 idle");          rd(8'h02, "R6 low-voltage flag");
    pulse(5'b10000, 1'b0, "R10 idle"); pulse(5'b00001, 1'b0, "R10 idle");
    pulse(5'b01000, 1'b0, "R10 idle");         rd(8'h62, "R10 accumulate");
    pulse(5'b01000, 1'b0, "R11 idle");
    tick(1'b0, 5'b10000, 1'b0, 1'b1, 1'b0, REG, 8'h20, "R11 read returns old");
    rd(8'h40, "R11 set wins over clear");
    pulse(5'b00100, 1'b0, "R12 idle");
    tick(1'b0, 5'b0, 1'b0, 1'b1, 1'b0, REG ^ 8'h01, 8'h00, "R12 miss read data");
    tick(1'b0, 5'b0, 1'b0, 1'b1, 1'b1, REG, 8'h00, "R13 write data");
    rd(8'h10, "R12 R13 flags kept");
    pulse(5'b00001, 1'b0, "R1 idle");
    tick(1'b1, 5'b11111, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R1 reset with sources");
    rd(8'h80, "R1 power-on overrides");
    pulse(5'b11111, 1'b1, "R7 idle");
    rd(8'h7A, "R7 unused bits zero");

    for (int i = 0; i < 800; i++) begin
      logic p, f, e, w, hit;
      logic [4:0] s;
      logic [7:0] a, exp;
      int k;
      p = ($urandom_range(0, 99) == 0);
      for (int j = 0; j < 5; j++) s[j] = ($urandom_range(0, 9) == 0);
      f = $urandom_range(0, 1);
      k = $urandom_range(0, 7);
      e = (k < 5);
      w = (k == 4);
      a = (k < 3 || k == 4) ? REG : 8'($urandom_range(0, 255));
      hit = e && !w && (a == REG);
      exp = (hit && !p) ? model : 8'h00;
      tick(p, s, f, e, w, a, exp, hit ? "R8 random read" : "R9 random idle");
    end
    tick(1'b0, 5'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9 final idle");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule